// File: doc/BRIEF.md
# Service Acknowledge Vector Unit

This unit answers the host's service-acknowledge accesses in a multi-channel serial controller. Three kinds of service can be requested: receive, transmit and modem-signal change. For each kind the host programs a match register with the address of that kind's acknowledge location. When an acknowledge access arrives, the unit compares its address with the three match registers. It then returns an 8-bit vector. The upper five bits are the device identity, taken from a host-written vector register. The lower three bits are a type code filled in by hardware.

A granted acknowledge puts its type in service. Further requests of that type are masked until the host pulses that type's end-of-service strobe. The stored vector register byte is never changed by an acknowledge. When register-based acknowledge is disabled, acknowledge accesses are ignored.

Top module: `sack_vector_unit`

## Requirements
- R1: After reset, the vector register reads 0xFF. The receive, transmit and modem match registers read 0x80, 0x81 and 0x82. `vec_valid_o` is low. The register addresses are 0x00 for the vector register and 0x01, 0x02 and 0x03 for the receive, transmit and modem match registers. Unmapped addresses read 0x00.
- R2: The vector register is written and read as a full byte. A read always returns the byte last written, even after acknowledges have inserted type codes.
- R3: Bits 7:3 of every returned vector equal bits 7:3 of the vector register at the time of the acknowledge.
- R4: The type code is placed in bits 2:0 of the returned vector. A granted receive returns 3, a granted transmit returns 2 and a granted modem-signal change returns 1. Codes 4, 5 and 6 are never returned.
- R5: A granted receive returns code 7 instead of 3 when `rx_exc_i` is high during the acknowledge.
- R6: An acknowledge returns a valid vector with code 000 in three cases: the address matches no match register, the matched type has no request, or the matched type is in service.
- R7: The acknowledge address selects the type whose match register equals it. If match registers are written with the same value, receive has priority over transmit, and transmit over modem.
- R8: While `ack_en_i` is low, an acknowledge strobe is ignored. No valid vector is produced and no in-service state changes.
- R9: Each enabled acknowledge strobe produces exactly one cycle of `vec_valid_o`, in the clock after the strobe is sampled. Acknowledges on consecutive cycles produce vectors on consecutive cycles, in the same order.
- R10: A granted acknowledge puts its type in service until an `eos_i` pulse for that type (bit 0 receive, bit 1 transmit, bit 2 modem). An end-of-service pulse in the same cycle as an acknowledge of that type does not let that acknowledge be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address for writes and reads |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ack_en_i | input | 1 | Register-based acknowledge enable |
| ack_stb_i | input | 1 | Acknowledge access strobe |
| ack_addr_i | input | AW | Acknowledge access address |
| req_rx_i | input | 1 | Receive service request |
| rx_exc_i | input | 1 | Pending receive is an exception |
| req_tx_i | input | 1 | Transmit service request |
| req_mdm_i | input | 1 | Modem-signal change request |
| eos_i | input | 3 | End-of-service strobes per type |
| vec_o | output | 8 | Returned vector |
| vec_valid_o | output | 1 | Vector valid, one cycle per acknowledge |

## Verification
The hardest case to reach is an acknowledge that meets an end-of-service pulse for its own type in the same clock. The bench first gets a receive granted, then raises the acknowledge strobe and the receive end-of-service strobe in the same cycle, and expects 000 followed by a granted retry. The duplicate-match priority is reached by rewriting the transmit match register onto the receive address and requesting only transmit. Back-to-back strobes with different types check ordering and the single-cycle valid pulse.

// File: rtl/sack_pkg.sv
package sack_pkg;
  localparam int NTYPE = 3;
  localparam int T_RX  = 0;
  localparam int T_TX  = 1;
  localparam int T_MDM = 2;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_MDM  = 3'd1;
  localparam logic [2:0] CODE_TX   = 3'd2;
  localparam logic [2:0] CODE_RXG  = 3'd3;
  localparam logic [2:0] CODE_RXX  = 3'd7;
endpackage

// File: rtl/sack_regs.sv
module sack_regs
  import sack_pkg::*;
#(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  ADDR_VEC = 'h00,
  parameter logic [AW-1:0]  ADDR_MRX = 'h01,
  parameter logic [AW-1:0]  ADDR_MTX = 'h02,
  parameter logic [AW-1:0]  ADDR_MMD = 'h03,
  parameter logic [AW-1:0]  RST_MRX  = 'h80,
  parameter logic [AW-1:0]  RST_MTX  = 'h81,
  parameter logic [AW-1:0]  RST_MMD  = 'h82
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 rdata_o,
  output logic [4:0]                 id_o,
  output logic [NTYPE-1:0][AW-1:0]   match_o
);
  localparam logic [NTYPE-1:0][AW-1:0] MADDR = {ADDR_MMD, ADDR_MTX, ADDR_MRX};
  localparam logic [NTYPE-1:0][AW-1:0] MRST  = {RST_MMD, RST_MTX, RST_MRX};

  logic [7:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         vec_q <= 8'hFF;
    else if (wr_i && addr_i == ADDR_VEC) vec_q <= wdata_i;
  end

  for (genvar t = 0; t < NTYPE; t++) begin : g_match
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             match_o[t] <= MRST[t];
      else if (wr_i && addr_i == MADDR[t])     match_o[t] <= wdata_i[AW-1:0];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == ADDR_VEC) rdata_o = vec_q;
    for (int t = 0; t < NTYPE; t++)
      if (addr_i == MADDR[t]) rdata_o = 8'(match_o[t]);
  end

  assign id_o = vec_q[7:3];
endmodule

// File: rtl/sack_match.sv
module sack_match
  import sack_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0]             addr_i,
  input  logic [NTYPE-1:0][AW-1:0]  match_i,
  output logic [NTYPE-1:0]          sel_o
);
  logic [NTYPE-1:0] hit;

  for (genvar t = 0; t < NTYPE; t++) begin : g_cmp
    assign hit[t] = (addr_i == match_i[t]);
  end

  // lowest index wins on duplicate match values
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel_o = '0;
    for (int t = 0; t < NTYPE; t++) begin
      sel_o[t] = hit[t] && !taken;
      taken    = taken || hit[t];
    end
  end
endmodule

// File: rtl/sack_service.sv
module sack_service
  import sack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic [NTYPE-1:0]  sel_i,
  input  logic [NTYPE-1:0]  req_i,
  input  logic              rx_exc_i,
  input  logic [NTYPE-1:0]  eos_i,
  output logic [2:0]        code_o
);
  logic [NTYPE-1:0] busy_q, grant;

  assign grant = sel_i & req_i & ~busy_q & {NTYPE{ack_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~eos_i) | grant;
  end

  always_comb begin
    code_o = CODE_NONE;
    if (grant[T_RX])       code_o = rx_exc_i ? CODE_RXX : CODE_RXG;
    else if (grant[T_TX])  code_o = CODE_TX;
    else if (grant[T_MDM]) code_o = CODE_MDM;
  end
endmodule

// File: rtl/sack_vector_unit.sv
module sack_vector_unit
  import sack_pkg::*;
#(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  ADDR_VEC = 'h00,
  parameter logic [AW-1:0]  ADDR_MRX = 'h01,
  parameter logic [AW-1:0]  ADDR_MTX = 'h02,
  parameter logic [AW-1:0]  ADDR_MMD = 'h03,
  parameter logic [AW-1:0]  RST_MRX  = 'h80,
  parameter logic [AW-1:0]  RST_MTX  = 'h81,
  parameter logic [AW-1:0]  RST_MMD  = 'h82
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          ack_en_i,
  input  logic          ack_stb_i,
  input  logic [AW-1:0] ack_addr_i,
  input  logic          req_rx_i,
  input  logic          rx_exc_i,
  input  logic          req_tx_i,
  input  logic          req_mdm_i,
  input  logic [2:0]    eos_i,
  output logic [7:0]    vec_o,
  output logic          vec_valid_o
);
  logic [4:0]                id;
  logic [NTYPE-1:0][AW-1:0]  match;
  logic [NTYPE-1:0]          sel, req;
  logic [2:0]                code;
  logic                      ack;

  assign ack = ack_stb_i && ack_en_i;
  assign req = {req_mdm_i, req_tx_i, req_rx_i};

  sack_regs #(
    .AW(AW), .ADDR_VEC(ADDR_VEC), .ADDR_MRX(ADDR_MRX), .ADDR_MTX(ADDR_MTX),
    .ADDR_MMD(ADDR_MMD), .RST_MRX(RST_MRX), .RST_MTX(RST_MTX), .RST_MMD(RST_MMD)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .id_o(id), .match_o(match)
  );

  sack_match #(.AW(AW)) u_match (
    .addr_i(ack_addr_i), .match_i(match), .sel_o(sel)
  );

  sack_service u_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack), .sel_i(sel), .req_i(req),
    .rx_exc_i(rx_exc_i), .eos_i(eos_i), .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= 8'h00;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= ack;
      if (ack) vec_o <= {id, code};
    end
  end
endmodule

// File: rtl/sack_checker.sv
module sack_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_en_i,
  input logic       ack_stb_i,
  input logic       req_rx_i,
  input logic       rx_exc_i,
  input logic       req_tx_i,
  input logic       req_mdm_i,
  input logic [7:0] vec_o,
  input logic       vec_valid_o
);
  assert_no_reserved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !(vec_o[2:0] inside {3'd4, 3'd5, 3'd6}));

  assert_vec_after_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_stb_i && ack_en_i) |=> vec_valid_o);

  assert_silent_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_stb_i && ack_en_i) |=> !vec_valid_o);

  assert_idle_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_stb_i && ack_en_i && !req_rx_i && !req_tx_i && !req_mdm_i)
      |=> (vec_o[2:0] == 3'd0));

  assert_exc_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_o[2:0] == 3'd7) |-> $past(rx_exc_i && req_rx_i));
endmodule

bind sack_vector_unit sack_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_en_i(ack_en_i), .ack_stb_i(ack_stb_i),
  .req_rx_i(req_rx_i), .rx_exc_i(rx_exc_i), .req_tx_i(req_tx_i),
  .req_mdm_i(req_mdm_i), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
);

// File: tb/tb_sack_vector_unit.sv
module tb_sack_vector_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_wr = 0, ack_en = 1, ack_stb = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, ack_addr = 0;
  logic       req_rx = 0, rx_exc = 0, req_tx = 0, req_mdm = 0;
  logic [2:0] eos = 0;
  logic [7:0] reg_rdata, vec;
  logic       vec_valid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sack_vector_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ack_en_i(ack_en),
    .ack_stb_i(ack_stb), .ack_addr_i(ack_addr), .req_rx_i(req_rx),
    .rx_exc_i(rx_exc), .req_tx_i(req_tx), .req_mdm_i(req_mdm), .eos_i(eos),
    .vec_o(vec), .vec_valid_o(vec_valid)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9/R8 unexpected valid: actual %h expected none", vec);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, vec, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string t);
    @(negedge clk); reg_addr = a; #1;
    chk(t, reg_rdata, exp);
  endtask

  task automatic ack(input logic [7:0] a, input logic [7:0] exp, input string t);
    @(negedge clk); ack_addr = a; ack_stb = 1;
    exp_q.push_back(exp); tag_q.push_back(t);
    @(negedge clk); ack_stb = 0;
  endtask

  task automatic end_svc(input int t);
    @(negedge clk); eos[t] = 1;
    @(negedge clk); eos = 0;
  endtask

  task automatic drain(input string t);
    repeat (2) @(negedge clk);
    chk(t, 8'(exp_q.size()), 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {7'd0, vec_valid}, 8'd0);
    rd(8'h00, 8'hFF, "R1 vec reg");
    rd(8'h01, 8'h80, "R1 match rx");
    rd(8'h02, 8'h81, "R1 match tx");
    rd(8'h03, 8'h82, "R1 match mdm");
    rd(8'h3C, 8'h00, "R1 unmapped");
    // R2 full byte write
    wr(8'h00, 8'hA5);
    rd(8'h00, 8'hA5, "R2 vec readback");
    // R4/R3 receive good, then R10 masking
    req_rx = 1;
    ack(8'h80, 8'hA3, "R4 rx good");
    ack(8'h80, 8'hA0, "R10 rx in service");
    end_svc(0);
    ack(8'h80, 8'hA3, "R10 rx after eos");
    end_svc(0);
    req_rx = 0;
    // R4 transmit and modem
    req_tx = 1; req_mdm = 1;
    ack(8'h81, 8'hA2, "R4 tx");
    ack(8'h82, 8'hA1, "R4 mdm");
    end_svc(1); end_svc(2);
    req_tx = 0; req_mdm = 0;
    // R5 exception
    req_rx = 1; rx_exc = 1;
    ack(8'h80, 8'hA7, "R5 rx exception");
    end_svc(0);
    rx_exc = 0; req_rx = 0;
    // R6 no pending / unmatched
    ack(8'h81, 8'hA0, "R6 tx not pending");
    req_rx = 1; req_tx = 1; req_mdm = 1;
    ack(8'h55, 8'hA0, "R6 unmatched address");
    req_tx = 0; req_mdm = 0;
    // R2 stored byte unaffected by inserted codes
    rd(8'h00, 8'hA5, "R2 vec after acks");
    // R3 new identity
    wr(8'h00, 8'h3E);
    ack(8'h80, 8'h3B, "R3 new id rx");
    end_svc(0);
    wr(8'h00, 8'hA5);
    // R8 disabled acknowledge ignored
    @(negedge clk); ack_en = 0; ack_addr = 8'h80; ack_stb = 1;
    @(negedge clk); ack_stb = 0;
    drain("R8 no vector while disabled");
    ack_en = 1;
    ack(8'h80, 8'hA3, "R8 no service state change");
    end_svc(0);
    req_rx = 0;
    // R7 duplicate priority and reprogrammed match
    wr(8'h02, 8'h80);
    rd(8'h02, 8'h80, "R7 match tx write");
    req_tx = 1;
    ack(8'h80, 8'hA0, "R7 rx beats tx on duplicate");
    wr(8'h02, 8'h81);
    ack(8'h81, 8'hA2, "R7 tx restored");
    end_svc(1); req_tx = 0;
    wr(8'h03, 8'h90);
    req_mdm = 1;
    ack(8'h82, 8'hA0, "R7 old mdm address unmatched");
    ack(8'h90, 8'hA1, "R7 mdm new address");
    end_svc(2); req_mdm = 0;
    // R9 back-to-back
    req_rx = 1; req_tx = 1;
    @(negedge clk); ack_addr = 8'h80; ack_stb = 1;
    exp_q.push_back(8'hA3); tag_q.push_back("R9 first of pair");
    @(negedge clk); ack_addr = 8'h81;
    exp_q.push_back(8'hA2); tag_q.push_back("R9 second of pair");
    @(negedge clk); ack_stb = 0;
    drain("R9 pair drained");
    end_svc(1); req_tx = 0;
    // R10 eos coincident with ack (rx in service)
    @(negedge clk); ack_addr = 8'h80; ack_stb = 1; eos = 3'b001;
    exp_q.push_back(8'hA0); tag_q.push_back("R10 eos same cycle");
    @(negedge clk); ack_stb = 0; eos = 0;
    ack(8'h80, 8'hA3, "R10 retry granted");
    drain("R10 drained");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #10 rst_n = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule